// File: doc/BRIEF.md
# Transfer Descriptor Ring Walker

The block runs one endpoint queue of a USB-style device controller. It follows a circular linked list of 16-byte transfer descriptors held in system memory and reads each one as four 32-bit words over a simple request/acknowledge memory port. It then decides whether the descriptor belongs to hardware, whether it is to be skipped, and (when enabled) whether its checksum is intact. For a live descriptor it offers the buffer address and length to an external data mover and waits for that transfer to finish. It then writes the results back to the descriptor, gives the descriptor back to software and moves on to the next-descriptor pointer.

Software places the ring in memory, sets the ownership flag on each descriptor it hands over, and pulses the start strobe with the address of the first descriptor. When the walker meets a descriptor that software has not handed over, it parks until it receives a resume strobe. A checksum failure stops the queue until the next start. Each queue has a direction, latched at start. An outbound queue sends buffer contents and may ask for a trailing zero-length packet. An inbound queue records how many bytes arrived.

Top module: `qdw_ring_walker`

## Requirements
- R1: After reset the walker is idle: no memory request, no transfer offer, both interrupt outputs low, and the current-pointer output is 0.
- R2: A start pulse latches the start address as the current pointer, along with the direction (`dir_tx_i`, 1 = outbound) and the checksum enable. The walker then reads the four descriptor words at pointer+0, +4, +8 and +12. Word layout: word0 bits 7:0 flags, bits 15:8 checksum, bits 31:16 inbound buffer length; word1 next pointer; word2 buffer pointer; word3 bits 15:0 data length, bits 23:16 extension flags.
- R3: A descriptor whose ownership flag (flags bit 0) is 0 produces no transfer and no write, and the current pointer stays on it. The walker re-reads it only after a `resume_i` pulse.
- R4: A descriptor with ownership 1 and the skip flag (flags bit 2) set produces no transfer and no write. The walker goes on to its next pointer.
- R5: For a live descriptor, `xfer_valid_o` rises with the buffer pointer as address. The length is word3 bits 15:0 for outbound queues and word0 bits 31:16 for inbound queues. Address, length and valid stay unchanged until `xfer_done_i`.
- R6: `xfer_zlp_o` follows extension-flag bit 5 (word3 bit 21) on outbound queues and is 0 on inbound queues.
- R7: On an inbound queue, after the transfer the walker writes word3 with bits 15:0 replaced by `xfer_count_i` and bits 31:16 unchanged. An outbound queue does not write word3.
- R8: Writeback then stores word0 with only bit 0 cleared, and the walker follows the next pointer (word1).
- R9: When flags bit 7 is set, `done_irq_o` pulses for one cycle after the word0 writeback. When it is clear, `done_irq_o` stays low.
- R10: With checksum checking enabled, an owned descriptor whose 16 bytes do not sum to 0xFF modulo 256 raises a one-cycle `csum_err_irq_o`. It then gets no transfer and no writeback, and the walker halts. A resume pulse does not restart it; only start does. Ownership is tested before the checksum. With checking disabled, the checksum byte has no effect.
- R11: A memory request holds a stable, word-aligned address until `mem_ack_i`. A write of word0 never has bit 0 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; loads pointer, direction, checksum enable |
| start_addr_i | input | ADDR_W | First descriptor address |
| resume_i | input | 1 | Re-poll strobe while parked on a non-owned descriptor |
| dir_tx_i | input | 1 | Queue direction, 1 = outbound, sampled at start |
| csum_en_i | input | 1 | Checksum check enable, sampled at start |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Byte address, word aligned |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Access done; read data valid in this cycle |
| mem_rdata_i | input | 32 | Read data |
| xfer_valid_o | output | 1 | Transfer offer to the data mover |
| xfer_addr_o | output | ADDR_W | Data buffer address |
| xfer_len_o | output | 16 | Transfer length in bytes |
| xfer_zlp_o | output | 1 | Append zero-length packet (outbound only) |
| xfer_done_i | input | 1 | Data mover finished |
| xfer_count_i | input | 16 | Bytes received (inbound) |
| cur_ptr_o | output | ADDR_W | Descriptor being processed |
| done_irq_o | output | 1 | Completion interrupt pulse |
| csum_err_irq_o | output | 1 | Checksum error interrupt pulse |

## Verification
The assertions rely on the memory answering with `mem_ack_i` only in a cycle when `mem_req_o` is high. They rely on the data mover raising `xfer_done_i` only while an offer is pending. They also rely on start being pulsed only while the walker is idle, parked or halted. The bench's memory model acknowledges each request exactly once, one cycle after it appears. Its data-mover model answers three cycles into an offer. The bench also issues start only after a descriptor chain has settled.

// File: rtl/qdw_pkg.sv
package qdw_pkg;
  localparam int WORD_W     = 32;
  localparam int DESC_WORDS = 4;
  localparam int DESC_BYTES = DESC_WORDS * WORD_W / 8;
  localparam int LEN_W      = 16;
  localparam int CNT_W      = $clog2(DESC_WORDS);

  localparam int FLG_OWN  = 0;
  localparam int FLG_SKIP = 2;
  localparam int FLG_IOC  = 7;
  localparam int EXT_ZLP  = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_EVAL, ST_PARK, ST_MOVE, ST_WB_LEN, ST_WB_FLG, ST_HALT
  } walk_st_e;

  typedef struct packed {
    logic             own;
    logic             skip;
    logic             ioc;
    logic             zlp;
    logic             csum_ok;
    logic [WORD_W-1:0] next_ptr;
    logic [WORD_W-1:0] buf_ptr;
    logic [LEN_W-1:0]  xfer_len;
  } desc_info_t;
endpackage

// File: rtl/qdw_csum.sv
module qdw_csum #(
  parameter int NBYTES = 16
) (
  input  logic [NBYTES*8-1:0] data_i,
  output logic [7:0]          sum_o
);
  logic [7:0] part [NBYTES+1];
  assign part[0] = 8'h00;
  for (genvar g = 0; g < NBYTES; g++) begin : g_acc
    assign part[g+1] = part[g] + data_i[g*8 +: 8];
  end
  assign sum_o = part[NBYTES];
endmodule

// File: rtl/qdw_decode.sv
module qdw_decode
  import qdw_pkg::*;
(
  input  logic [DESC_WORDS*WORD_W-1:0] desc_i,
  input  logic                         dir_tx_i,
  output desc_info_t                   info_o
);
  logic [7:0] sum;
  logic [WORD_W-1:0] w0, w1, w2, w3;

  assign w0 = desc_i[0*WORD_W +: WORD_W];
  assign w1 = desc_i[1*WORD_W +: WORD_W];
  assign w2 = desc_i[2*WORD_W +: WORD_W];
  assign w3 = desc_i[3*WORD_W +: WORD_W];

  qdw_csum #(.NBYTES(DESC_BYTES)) u_csum (.data_i(desc_i), .sum_o(sum));

  always_comb begin
    info_o.own      = w0[FLG_OWN];
    info_o.skip     = w0[FLG_SKIP];
    info_o.ioc      = w0[FLG_IOC];
    info_o.zlp      = dir_tx_i & w3[16 + EXT_ZLP];
    info_o.csum_ok  = (sum == 8'hFF);
    info_o.next_ptr = w1;
    info_o.buf_ptr  = w2;
    info_o.xfer_len = dir_tx_i ? w3[LEN_W-1:0] : w0[31:16];
  end
endmodule

// File: rtl/qdw_ring_walker.sv
module qdw_ring_walker
  import qdw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              resume_i,
  input  logic              dir_tx_i,
  input  logic              csum_en_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              xfer_valid_o,
  output logic [ADDR_W-1:0] xfer_addr_o,
  output logic [15:0]       xfer_len_o,
  output logic              xfer_zlp_o,
  input  logic              xfer_done_i,
  input  logic [15:0]       xfer_count_i,
  output logic [ADDR_W-1:0] cur_ptr_o,
  output logic              done_irq_o,
  output logic              csum_err_irq_o
);
  localparam int LEN_OFS = (DESC_WORDS - 1) * (WORD_W / 8);

  walk_st_e                       state_q;
  logic [ADDR_W-1:0]              cur_q;
  logic [CNT_W-1:0]               wcnt_q;
  logic [DESC_WORDS-1:0][WORD_W-1:0] desc_q;
  logic                           dir_q, csen_q;
  logic [LEN_W-1:0]               cnt_q;
  logic                           done_q, err_q;
  desc_info_t                     info;

  qdw_decode u_dec (.desc_i(desc_q), .dir_tx_i(dir_q), .info_o(info));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      wcnt_q  <= '0;
      desc_q  <= '0;
      dir_q   <= 1'b0;
      csen_q  <= 1'b0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        ST_IDLE, ST_PARK, ST_HALT: begin
          if (start_i) begin
            cur_q   <= start_addr_i;
            dir_q   <= dir_tx_i;
            csen_q  <= csum_en_i;
            wcnt_q  <= '0;
            state_q <= ST_FETCH;
          end else if (state_q == ST_PARK && resume_i) begin
            wcnt_q  <= '0;
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (mem_ack_i) begin
            desc_q[wcnt_q] <= mem_rdata_i;
            if (wcnt_q == CNT_W'(DESC_WORDS - 1)) state_q <= ST_EVAL;
            else wcnt_q <= wcnt_q + 1'b1;
          end
        end
        ST_EVAL: begin
          // ownership first, then integrity, then skip
          if (!info.own) begin
            state_q <= ST_PARK;
          end else if (csen_q && !info.csum_ok) begin
            err_q   <= 1'b1;
            state_q <= ST_HALT;
          end else if (info.skip) begin
            cur_q   <= info.next_ptr[ADDR_W-1:0];
            wcnt_q  <= '0;
            state_q <= ST_FETCH;
          end else begin
            state_q <= ST_MOVE;
          end
        end
        ST_MOVE: begin
          if (xfer_done_i) begin
            cnt_q   <= xfer_count_i;
            state_q <= dir_q ? ST_WB_FLG : ST_WB_LEN;
          end
        end
        ST_WB_LEN: if (mem_ack_i) state_q <= ST_WB_FLG;
        ST_WB_FLG: begin
          if (mem_ack_i) begin
            done_q  <= info.ioc;
            cur_q   <= info.next_ptr[ADDR_W-1:0];
            wcnt_q  <= '0;
            state_q <= ST_FETCH;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = cur_q;
    mem_wdata_o = '0;
    case (state_q)
      ST_FETCH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = cur_q + ADDR_W'({wcnt_q, 2'b00});
      end
      ST_WB_LEN: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = cur_q + ADDR_W'(LEN_OFS);
        mem_wdata_o = {desc_q[DESC_WORDS-1][WORD_W-1:LEN_W], cnt_q};
      end
      ST_WB_FLG: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_wdata_o = {desc_q[0][WORD_W-1:1], 1'b0};
      end
      default: ;
    endcase
  end

  assign xfer_valid_o   = (state_q == ST_MOVE);
  assign xfer_addr_o    = info.buf_ptr[ADDR_W-1:0];
  assign xfer_len_o     = info.xfer_len;
  assign xfer_zlp_o     = info.zlp;
  assign cur_ptr_o      = cur_q;
  assign done_irq_o     = done_q;
  assign csum_err_irq_o = err_q;
endmodule

// File: rtl/qdw_ring_walker_chk.sv
module qdw_ring_walker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [31:0]       mem_wdata_o,
  input logic              mem_ack_i,
  input logic              xfer_valid_o,
  input logic [ADDR_W-1:0] xfer_addr_o,
  input logic [15:0]       xfer_len_o,
  input logic              xfer_done_i,
  input logic [ADDR_W-1:0] cur_ptr_o,
  input logic              done_irq_o,
  input logic              csum_err_irq_o
);
  // R11
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  // R11
  addr_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);

  // R11
  own_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_addr_o == cur_ptr_o |-> !mem_wdata_o[0]);

  // R5
  offer_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_o && !xfer_done_i |=> xfer_valid_o && $stable(xfer_addr_o) && $stable(xfer_len_o));

  // R10
  halt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csum_err_irq_o && !start_i |=> !mem_req_o && !xfer_valid_o);

  // R10
  err_no_offer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csum_err_irq_o |-> !xfer_valid_o && !mem_req_o);

  // R9
  irq_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_irq_o, csum_err_irq_o}));

  // R9
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_irq_o |=> !done_irq_o);
endmodule

bind qdw_ring_walker qdw_ring_walker_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_qdw_ring_walker.sv
`timescale 1ns/1ps
module tb_qdw_ring_walker;
  localparam int AW = 32;
  localparam logic [31:0] A_ADR = 32'h40;
  localparam logic [31:0] B_ADR = 32'h80;

  typedef struct packed {
    logic        dir;
    logic        csen;
    logic        bad;
    logic [7:0]  flags;
    logic [7:0]  ext;
    logic [15:0] tlen;
    logic [15:0] rxlen;
    logic [15:0] cnt;
    logic        ex_x;
    logic        ex_irq;
    logic        ex_err;
    logic [7:0]  ex_flags;
    logic [15:0] ex_len;
    logic        ex_at_b;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b0,1'b0,1'b0,8'h81,8'h20,16'h1111,16'h0200,16'h0033,1'b1,1'b1,1'b0,8'h80,16'h0033,1'b1},
    '{1'b1,1'b0,1'b1,8'h01,8'h20,16'h0040,16'h0000,16'h0000,1'b1,1'b0,1'b0,8'h00,16'h0040,1'b1},
    '{1'b1,1'b1,1'b0,8'h81,8'h00,16'h0100,16'h0000,16'h0000,1'b1,1'b1,1'b0,8'h80,16'h0100,1'b1},
    '{1'b0,1'b1,1'b1,8'h81,8'h00,16'h0010,16'h0020,16'h0005,1'b0,1'b0,1'b1,8'h81,16'h0010,1'b0},
    '{1'b0,1'b0,1'b0,8'h05,8'h00,16'h0077,16'h0020,16'h0005,1'b0,1'b0,1'b0,8'h05,16'h0077,1'b1},
    '{1'b0,1'b0,1'b0,8'h84,8'h00,16'h0066,16'h0020,16'h0005,1'b0,1'b0,1'b0,8'h84,16'h0066,1'b0}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, resume_i = 1'b0, dir_tx_i = 1'b0, csum_en_i = 1'b0;
  logic [AW-1:0] start_addr_i = '0;
  logic mem_req_o, mem_we_o, mem_ack_i;
  logic [AW-1:0] mem_addr_o;
  logic [31:0] mem_wdata_o, mem_rdata_i;
  logic xfer_valid_o, xfer_zlp_o, xfer_done_i;
  logic [AW-1:0] xfer_addr_o;
  logic [15:0] xfer_len_o, xfer_count_i;
  logic [AW-1:0] cur_ptr_o;
  logic done_irq_o, csum_err_irq_o;

  always #5 clk_i = ~clk_i;

  qdw_ring_walker #(.ADDR_W(AW)) dut (.*);

  int n_chk = 0, n_fail = 0;
  logic [31:0] mem [64];
  logic        tb_we = 1'b0;
  logic [5:0]  tb_idx = '0;
  logic [31:0] tb_dat = '0;
  logic [15:0] rx_val = '0;

  // memory: one-cycle acknowledge
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_ack_i   <= 1'b0;
      mem_rdata_i <= '0;
    end else begin
      if (tb_we) mem[tb_idx] <= tb_dat;
      if (mem_req_o && !mem_ack_i) begin
        mem_ack_i <= 1'b1;
        if (mem_we_o) mem[mem_addr_o[7:2]] <= mem_wdata_o;
        else mem_rdata_i <= mem[mem_addr_o[7:2]];
      end else begin
        mem_ack_i <= 1'b0;
      end
    end
  end

  // data mover and interrupt counters
  int mv_wait = 0, n_xfer = 0, n_done = 0, n_err = 0;
  logic [AW-1:0] cap_addr = '0;
  logic [15:0]   cap_len = '0;
  logic          cap_zlp = 1'b0;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xfer_done_i  <= 1'b0;
      xfer_count_i <= '0;
      mv_wait      <= 0;
    end else begin
      if (done_irq_o) n_done <= n_done + 1;
      if (csum_err_irq_o) n_err <= n_err + 1;
      if (xfer_valid_o && !xfer_done_i) begin
        mv_wait <= mv_wait + 1;
        if (mv_wait == 2) begin
          xfer_done_i  <= 1'b1;
          xfer_count_i <= rx_val;
          cap_addr     <= xfer_addr_o;
          cap_len      <= xfer_len_o;
          cap_zlp      <= xfer_zlp_o;
          n_xfer       <= n_xfer + 1;
        end
      end else begin
        xfer_done_i <= 1'b0;
        mv_wait     <= 0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] adr, input logic [31:0] dat);
    @(negedge clk_i);
    tb_we = 1'b1; tb_idx = adr[7:2]; tb_dat = dat;
    @(negedge clk_i);
    tb_we = 1'b0;
  endtask

  task automatic put_desc(input logic [31:0] adr, input logic [7:0] flg, input logic bad,
                          input logic [15:0] rxl, input logic [31:0] nxt, input logic [31:0] bp,
                          input logic [15:0] tl, input logic [7:0] ext);
    logic [31:0] w3;
    logic [7:0]  s, cs;
    w3 = {8'h00, ext, tl};
    s = flg + rxl[7:0] + rxl[15:8];
    for (int i = 0; i < 4; i++) s = s + nxt[i*8 +: 8] + bp[i*8 +: 8] + w3[i*8 +: 8];
    cs = 8'hFF - s + {7'd0, bad};
    poke(adr,      {rxl, cs, flg});
    poke(adr + 4,  nxt);
    poke(adr + 8,  bp);
    poke(adr + 12, w3);
  endtask

  task automatic pulse_start(input logic [31:0] adr, input logic dir, input logic csen);
    @(negedge clk_i);
    start_i = 1'b1; start_addr_i = adr; dir_tx_i = dir; csum_en_i = csen;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic pulse_resume();
    @(negedge clk_i); resume_i = 1'b1;
    @(negedge clk_i); resume_i = 1'b0;
  endtask

  task automatic settle();
    repeat (80) @(posedge clk_i);
    #2;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int x0, d0, e0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    #23;
    // R1 reset state
    check(!mem_req_o && !xfer_valid_o && !done_irq_o && !csum_err_irq_o, "R1 idle", {mem_req_o, xfer_valid_o}, 0);
    check(cur_ptr_o == 0, "R1 cur_ptr", cur_ptr_o, 0);
    rst_ni = 1'b1;
    repeat (3) @(posedge clk_i);
    #2;
    check(!mem_req_o && cur_ptr_o == 0, "R1 after release", cur_ptr_o, 0);

    // table walk: descriptor at A, terminator (not owned) at B
    for (int v = 0; v < 6; v++) begin
      vec_t t;
      logic [15:0] elen;
      t = VEC[v];
      rx_val = t.cnt;
      put_desc(A_ADR, t.flags, t.bad, t.rxlen, B_ADR, 32'h1000 + v * 32'h100, t.tlen, t.ext);
      put_desc(B_ADR, 8'h00, 1'b0, 16'h0, A_ADR, 32'h0, 16'h0, 8'h00);
      x0 = n_xfer; d0 = n_done; e0 = n_err;
      pulse_start(A_ADR, t.dir, t.csen);
      settle();
      // R2 R3 R4 R5 R10: transfer taken or withheld
      check((n_xfer - x0) == int'(t.ex_x), $sformatf("R2/R3/R4/R10 v%0d xfer count", v), n_xfer - x0, t.ex_x);
      if (t.ex_x) begin
        elen = t.dir ? t.tlen : t.rxlen;
        check(cap_addr == 32'h1000 + v * 32'h100, $sformatf("R5 v%0d addr", v), cap_addr, 32'h1000 + v * 32'h100);
        check(cap_len == elen, $sformatf("R5 v%0d len", v), cap_len, elen);
        check(cap_zlp == (t.dir & t.ext[5]), $sformatf("R6 v%0d zlp", v), cap_zlp, t.dir & t.ext[5]);
      end
      check(mem[A_ADR[7:2]][7:0] == t.ex_flags, $sformatf("R8/R10 v%0d flags", v), mem[A_ADR[7:2]][7:0], t.ex_flags);
      check(mem[A_ADR[7:2] + 3][15:0] == t.ex_len, $sformatf("R7 v%0d len field", v), mem[A_ADR[7:2] + 3][15:0], t.ex_len);
      check(mem[A_ADR[7:2] + 3][23:16] == t.ext, $sformatf("R7 v%0d upper word3", v), mem[A_ADR[7:2] + 3][23:16], t.ext);
      check((n_done - d0) == int'(t.ex_irq), $sformatf("R9 v%0d done irq", v), n_done - d0, t.ex_irq);
      check((n_err - e0) == int'(t.ex_err), $sformatf("R10 v%0d err irq", v), n_err - e0, t.ex_err);
      check(cur_ptr_o == (t.ex_at_b ? B_ADR : A_ADR), $sformatf("R3/R8 v%0d cur_ptr", v), cur_ptr_o, t.ex_at_b ? B_ADR : A_ADR);
    end

    // R3 resume: last vector left the walker parked on A; hand A over
    x0 = n_xfer; d0 = n_done;
    rx_val = 16'h0044;
    put_desc(A_ADR, 8'h81, 1'b0, 16'h0030, B_ADR, 32'h2000, 16'h0066, 8'h00);
    settle();
    check(n_xfer == x0 && cur_ptr_o == A_ADR, "R3 no action before resume", n_xfer - x0, 0);
    pulse_resume();
    settle();
    check(n_xfer - x0 == 1 && cap_len == 16'h0030, "R3 resume refetch", cap_len, 16'h0030);
    check(mem[A_ADR[7:2]][7:0] == 8'h80 && n_done - d0 == 1, "R8/R9 after resume", mem[A_ADR[7:2]][7:0], 8'h80);
    check(cur_ptr_o == B_ADR, "R8 follows next", cur_ptr_o, B_ADR);

    // two-entry ring walked in full, returns to A and parks
    x0 = n_xfer; d0 = n_done;
    rx_val = 16'h0009;
    put_desc(A_ADR, 8'h81, 1'b0, 16'h0010, B_ADR, 32'h3000, 16'h0000, 8'h00);
    put_desc(B_ADR, 8'h81, 1'b0, 16'h0020, A_ADR, 32'h3100, 16'h0000, 8'h00);
    pulse_start(A_ADR, 1'b0, 1'b1);
    settle();
    check(n_xfer - x0 == 2 && n_done - d0 == 2, "R8 ring of two", n_xfer - x0, 2);
    check(cap_addr == 32'h3100, "R5 second buffer", cap_addr, 32'h3100);
    check(mem[B_ADR[7:2] + 3][15:0] == 16'h0009 && mem[B_ADR[7:2]][7:0] == 8'h80, "R7 second writeback",
          mem[B_ADR[7:2] + 3][15:0], 16'h0009);
    check(cur_ptr_o == A_ADR, "R3 park on returned entry", cur_ptr_o, A_ADR);

    // R10 halt ignores resume
    x0 = n_xfer; e0 = n_err;
    put_desc(A_ADR, 8'h81, 1'b1, 16'h0010, B_ADR, 32'h4000, 16'h0000, 8'h00);
    pulse_start(A_ADR, 1'b0, 1'b1);
    settle();
    pulse_resume();
    settle();
    check(n_err - e0 == 1 && n_xfer == x0, "R10 halt holds after resume", n_err - e0, 1);
    check(mem[A_ADR[7:2]][7:0] == 8'h81 && cur_ptr_o == A_ADR, "R10 ownership kept", mem[A_ADR[7:2]][7:0], 8'h81);

    // R10 non-owned entry with bad checksum: ownership tested first
    e0 = n_err;
    put_desc(A_ADR, 8'h80, 1'b1, 16'h0010, B_ADR, 32'h4000, 16'h0000, 8'h00);
    pulse_start(A_ADR, 1'b0, 1'b1);
    settle();
    check(n_err == e0 && cur_ptr_o == A_ADR, "R10 ownership before checksum", n_err - e0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule